// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block is the CPU's data window into a network controller's packet memory. Each host access to the data port moves one unit between the host bus and a local synchronous RAM. The unit is a byte, a 16-bit half-word or a 32-bit word. The access goes through a remote address that advances by the access size and a remote byte count that runs down to zero. The address stays inside the receive ring, and the end of the count is reported as a one-cycle completion pulse. The register interface programs the address, the count, the ring start and stop pages and the data-width selection through dedicated load inputs. Only two host offsets are claimed: the data port at 0x10 and the reset port at 0x1F.

The engine is a three-state machine:
- `ST_IDLE` accepts requests. Every write completes here.
- A read moves `ST_IDLE -> ST_RESP`, which returns the data one cycle later.
- A read of the reset port continues `ST_RESP -> ST_PROM`, where eight word writes rebuild the 32-byte station-address PROM area. The machine then goes `ST_PROM -> ST_IDLE` after the eighth word.

While the machine is in `ST_RESP` or `ST_PROM`, `host_ready` is low.

Top module: `rdma_port`

## Requirements
- R1: After reset, `host_ready` is 1, `host_rvalid`, `dma_done` and `prom_event` are 0, and `cur_addr` and `cur_cnt` are 0.
- R2: The transfer size of a data-port access is 4 when `host_dword` is 1. Otherwise it is 2 when `cfg_wide` is 1, and 1 when `cfg_wide` is 0. After an access that performs an update, `cur_addr` has advanced by that size (modulo 2^ADDR_W).
- R3: If the advanced address equals the ring stop page times 256, the address becomes the ring start page times 256.
- R4: An updating access with a count not above the transfer size sets the count to 0 and pulses `dma_done` for one cycle on the next cycle. Any other updating access lowers the count by the transfer size and gives no pulse.
- R5: A data-port write while the count is 0 issues no memory write and changes neither the address nor the count, and `dma_done` stays 0.
- R6: A data-port read while the count is 0 still reads memory and advances the address, and it pulses `dma_done`.
- R7: The accessible range is bytes 0..31 plus the packet window, which by default is [0x4000, 0x8000). A read elsewhere returns 0xFF, 0xFFFF or 0xFFFFFFFF for byte, half-word or word size. A write elsewhere reaches no memory, but the address and count still update.
- R8: Half-word and word accesses clear address bit 0 before use. Data is little-endian: the byte at the lowest address is `host_wdata[7:0]` and `host_rdata[7:0]`. The whole access, including a word, must lie inside one range, or it counts as outside.
- R9: A read accepted on cycle N gives `host_rvalid` = 1 with data on cycle N+1 only, with `host_ready` low in that cycle.
- R10: A read of offset 0x1F returns 0 and pulses `prom_event` on the next cycle. It then writes 8 words to bytes 0..31 with all byte enables set.
  - Source bytes: 0..5 are `mac_addr` bytes, with byte 0 taken from `mac_addr[7:0]`. Bytes 6..13 are 0x00, and bytes 14..15 are 0x57.
  - Layout: source byte j lands at locations 2j and 2j+1.
- R11: For host offsets other than 0x10 and 0x1F, a read returns 0xFFFFFFFF and a write has no effect on memory, address or count.
- R12: An `addr_load` or `cnt_load` in the same cycle as a port update takes precedence for its own field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 selects 16-bit port transfers, 0 selects bytes |
| ring_start_pg | input | 8 | Ring start page (byte address / 256) |
| ring_stop_pg | input | 8 | Ring stop page (byte address / 256) |
| addr_load | input | 1 | Load the remote address from `addr_val` |
| addr_val | input | ADDR_W | Remote address load value |
| cnt_load | input | 1 | Load the remote count from `cnt_val` |
| cnt_val | input | CNT_W | Remote count load value |
| mac_addr | input | 48 | Station address, first byte in bits 7:0 |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 write, 0 read |
| host_dword | input | 1 | 32-bit access |
| host_ofs | input | 5 | Host offset |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Engine can accept a request |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data |
| cur_addr | output | ADDR_W | Current remote address |
| cur_cnt | output | CNT_W | Current remote count |
| dma_done | output | 1 | Remote DMA complete pulse |
| prom_event | output | 1 | Reset-port read pulse (sets reset status) |
| mem_req | output | 1 | RAM access |
| mem_we | output | 1 | RAM write |
| mem_addr | output | ADDR_W | RAM byte address of lane 0 |
| mem_be | output | 4 | Byte-lane enables, lane i is address + i |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, one cycle after the request |

## Verification
The bench targets several corner cases:
- **Ring wrap.** The address lands exactly on the stop page from byte, half-word and word steps. A design that compared with `>=` or wrapped before the add would leave the address at 0x8000 or skip a location.
- **Exhausted count.** A write at a zero count must not touch memory, while a read at a zero count must still advance and complete again. Swapping these rules shows up as stray data or a stalled address.
- **Access width at the edges.** It tries odd addresses in 16-bit mode, words that straddle the end of the window or of the PROM area, and out-of-range reads whose all-ones value must match the access width.
- **PROM rebuild.** It is read back word by word, which exposes any mistake in the doubled layout or the byte order.

// File: rtl/rdma_port_pkg.sv
package rdma_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RESP = 2'd1,
        ST_PROM = 2'd2
    } port_state_e;

    typedef enum logic [1:0] {
        XS_BYTE = 2'd0,
        XS_HALF = 2'd1,
        XS_WORD = 2'd2
    } xfer_size_e;

    typedef enum logic [1:0] {
        RK_MEM  = 2'd0,
        RK_ONES = 2'd1,
        RK_ZERO = 2'd2
    } resp_kind_e;

    localparam logic [4:0] DATA_OFS  = 5'h10;
    localparam logic [4:0] RESET_OFS = 5'h1F;

    function automatic int size_len(input xfer_size_e s);
        unique case (s)
            XS_BYTE: return 1;
            XS_HALF: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [3:0] size_be(input xfer_size_e s);
        unique case (s)
            XS_BYTE: return 4'b0001;
            XS_HALF: return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] size_mask(input xfer_size_e s);
        unique case (s)
            XS_BYTE: return 32'h0000_00FF;
            XS_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/rdma_window.sv
module rdma_window
    import rdma_port_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PMEM_BASE  = 16384,
    parameter int PMEM_BYTES = 16384,
    parameter int PROM_BYTES = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  xfer_size_e        size,
    output logic              ok
);
    localparam int EW = ADDR_W + 2;
    localparam logic [EW-1:0] PROM_END = EW'(PROM_BYTES);
    localparam logic [EW-1:0] WIN_LO   = EW'(PMEM_BASE);
    localparam logic [EW-1:0] WIN_HI   = EW'(PMEM_BASE + PMEM_BYTES);

    logic [EW-1:0] lo, hi;

    // The whole access [lo, hi) must sit inside one accessible range.
    always_comb begin
        lo = EW'(addr);
        hi = lo + EW'(size_len(size));
        ok = (hi <= PROM_END) || ((lo >= WIN_LO) && (hi <= WIN_HI));
    end
endmodule

// File: rtl/rdma_advance.sv
module rdma_advance
    import rdma_port_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    input  xfer_size_e        size,
    input  logic [7:0]        start_pg,
    input  logic [7:0]        stop_pg,
    output logic [ADDR_W-1:0] addr_nx,
    output logic [CNT_W-1:0]  cnt_nx,
    output logic              exhausted
);
    logic [ADDR_W-1:0] sum, start_b, stop_b;
    logic [CNT_W-1:0]  clen;

    always_comb begin
        start_b   = ADDR_W'({start_pg, 8'h00});
        stop_b    = ADDR_W'({stop_pg, 8'h00});
        sum       = addr + ADDR_W'(size_len(size));
        addr_nx   = (sum == stop_b) ? start_b : sum;
        clen      = CNT_W'(size_len(size));
        exhausted = (cnt <= clen);
        cnt_nx    = exhausted ? '0 : (cnt - clen);
    end
endmodule

// File: rtl/rdma_prom.sv
module rdma_prom (
    input  logic [2:0]  idx,
    input  logic [47:0] mac,
    output logic [31:0] word
);
    // Source byte j of the 16-byte pattern.
    function automatic logic [7:0] src_byte(input logic [3:0] j, input logic [47:0] m);
        if (j < 4'd6)
            return m[8*j +: 8];
        else if (j >= 4'd14)
            return 8'h57;
        else
            return 8'h00;
    endfunction

    // Word idx covers bytes 4*idx..4*idx+3, which hold source bytes 2*idx, 2*idx, 2*idx+1, 2*idx+1.
    for (genvar ln = 0; ln < 4; ln++) begin : g_lane
        assign word[8*ln +: 8] = src_byte({idx, 1'(ln / 2)}, mac);
    end
endmodule

// File: rtl/rdma_port.sv
module rdma_port
    import rdma_port_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int PMEM_BASE  = 16384,
    parameter int PMEM_BYTES = 16384,
    parameter int PROM_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic [7:0]        ring_start_pg,
    input  logic [7:0]        ring_stop_pg,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              cnt_load,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [47:0]       mac_addr,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_dword,
    input  logic [4:0]        host_ofs,
    input  logic [31:0]       host_wdata,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [31:0]       host_rdata,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              dma_done,
    output logic              prom_event,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    port_state_e       state_q, state_n;
    logic [ADDR_W-1:0] addr_q, addr_nx, acc_addr;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;
    logic              cnt_hit, win_ok;
    xfer_size_e        xsize;
    logic [2:0]        prom_idx;
    logic [31:0]       prom_word;
    resp_kind_e        resp_kind;
    logic [31:0]       resp_mask;
    logic              prom_pend;
    logic              done_q, prom_ev_q;
    logic              take, is_data, is_rst, rd_take, do_upd;

    // Decode of the request presented in ST_IDLE.
    always_comb begin
        take     = host_req && (state_q == ST_IDLE);
        is_data  = (host_ofs == DATA_OFS);
        is_rst   = (host_ofs == RESET_OFS);
        rd_take  = take && !host_we;
        xsize    = host_dword ? XS_WORD : (cfg_wide ? XS_HALF : XS_BYTE);
        acc_addr = (xsize == XS_BYTE) ? addr_q : {addr_q[ADDR_W-1:1], 1'b0};
        do_upd   = take && is_data && (!host_we || (cnt_q != '0));
    end

    rdma_window #(
        .ADDR_W    (ADDR_W),
        .PMEM_BASE (PMEM_BASE),
        .PMEM_BYTES(PMEM_BYTES),
        .PROM_BYTES(PROM_BYTES)
    ) u_win (
        .addr(acc_addr),
        .size(xsize),
        .ok  (win_ok)
    );

    rdma_advance #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_adv (
        .addr     (addr_q),
        .cnt      (cnt_q),
        .size     (xsize),
        .start_pg (ring_start_pg),
        .stop_pg  (ring_stop_pg),
        .addr_nx  (addr_nx),
        .cnt_nx   (cnt_nx),
        .exhausted(cnt_hit)
    );

    rdma_prom u_prom (
        .idx (prom_idx),
        .mac (mac_addr),
        .word(prom_word)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Transitions.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_take) state_n = ST_RESP;
            ST_RESP: state_n = prom_pend ? ST_PROM : ST_IDLE;
            ST_PROM: if (prom_idx == 3'd7) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs per state.
    always_comb begin
        host_ready  = 1'b0;
        host_rvalid = 1'b0;
        host_rdata  = '0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = acc_addr;
        mem_be      = size_be(xsize);
        mem_wdata   = host_wdata;
        unique case (state_q)
            ST_IDLE: begin
                host_ready = 1'b1;
                mem_req    = do_upd && win_ok;
                mem_we     = host_we;
            end
            ST_RESP: begin
                host_rvalid = 1'b1;
                unique case (resp_kind)
                    RK_MEM:  host_rdata = mem_rdata & resp_mask;
                    RK_ONES: host_rdata = resp_mask;
                    default: host_rdata = '0;
                endcase
            end
            ST_PROM: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ADDR_W'({prom_idx, 2'b00});
                mem_be    = 4'hF;
                mem_wdata = prom_word;
            end
            default: ;
        endcase
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            cnt_q     <= '0;
            done_q    <= 1'b0;
            prom_ev_q <= 1'b0;
            prom_pend <= 1'b0;
            prom_idx  <= '0;
            resp_kind <= RK_ZERO;
            resp_mask <= '0;
        end else begin
            done_q    <= 1'b0;
            prom_ev_q <= rd_take && is_rst;
            if (do_upd) begin
                addr_q <= addr_nx;
                cnt_q  <= cnt_nx;
                done_q <= cnt_hit;
            end
            if (addr_load) addr_q <= addr_val;
            if (cnt_load)  cnt_q  <= cnt_val;
            if (state_q == ST_IDLE) begin
                prom_pend <= rd_take && is_rst;
            end else if (state_q == ST_RESP) begin
                prom_pend <= 1'b0;
            end
            if (rd_take) begin
                if (is_data) begin
                    resp_kind <= win_ok ? RK_MEM : RK_ONES;
                    resp_mask <= size_mask(xsize);
                end else if (is_rst) begin
                    resp_kind <= RK_ZERO;
                    resp_mask <= '0;
                end else begin
                    resp_kind <= RK_ONES;
                    resp_mask <= 32'hFFFF_FFFF;
                end
            end
            if (state_q == ST_PROM) prom_idx <= prom_idx + 3'd1;
        end
    end

    assign cur_addr   = addr_q;
    assign cur_cnt    = cnt_q;
    assign dma_done   = done_q;
    assign prom_event = prom_ev_q;
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_we,
    input logic [4:0]        host_ofs,
    input logic              host_ready,
    input logic              host_rvalid,
    input logic              addr_load,
    input logic              cnt_load,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [CNT_W-1:0]  cur_cnt,
    input logic              dma_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_be
);
    // R9: accepted read answers on the next cycle, with the port busy.
    p_read_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && host_ready && !host_we |=> host_rvalid && !host_ready);

    // R9: read data is valid for a single cycle.
    p_rvalid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    // R5: a data write at zero count reaches no memory.
    p_zero_cnt_nomem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && host_ready && host_we && (host_ofs == 5'h10) && (cur_cnt == '0)
        |-> !mem_req);

    // R5: and leaves address, count and completion untouched.
    p_zero_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && host_ready && host_we && (host_ofs == 5'h10) && (cur_cnt == '0)
        && !addr_load && !cnt_load
        |=> $stable(cur_addr) && $stable(cur_cnt) && !dma_done);

    // R4: completion leaves a zero count unless a load intervened.
    p_done_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done && !$past(cnt_load) |-> (cur_cnt == '0));

    // R10: memory traffic while the port is busy is the PROM rebuild.
    p_prom_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !host_ready && !host_rvalid
        |-> mem_we && (mem_be == 4'hF) && (mem_addr[ADDR_W-1:5] == '0));

    // R8: wider accesses start on an even address.
    p_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && (mem_be != 4'b0001) |-> !mem_addr[0]);
endmodule

bind rdma_port rdma_port_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_ofs   (host_ofs),
    .host_ready (host_ready),
    .host_rvalid(host_rvalid),
    .addr_load  (addr_load),
    .cnt_load   (cnt_load),
    .cur_addr   (cur_addr),
    .cur_cnt    (cur_cnt),
    .dma_done   (dma_done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be)
);

// File: tb/sim_rdma_port.sv
module sim_rdma_port;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wide;
    logic [7:0]  ring_start_pg, ring_stop_pg;
    logic        addr_load;
    logic [15:0] addr_val;
    logic        cnt_load;
    logic [15:0] cnt_val;
    logic [47:0] mac_addr;
    logic        host_req, host_we, host_dword;
    logic [4:0]  host_ofs;
    logic [31:0] host_wdata;
    logic        host_ready, host_rvalid;
    logic [31:0] host_rdata;
    logic [15:0] cur_addr, cur_cnt;
    logic        dma_done, prom_event;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int stray   = 0;
    int m_addr  = 0;
    int m_cnt   = 0;
    bit [7:0] ram  [int];
    bit [7:0] refm [int];

    rdma_port u0 (.*);

    always #(CLK_NS/2) clk = ~clk;

    function automatic bit [7:0] ram_rd(input int a);
        return ram.exists(a) ? ram[a] : 8'h00;
    endfunction

    function automatic bit [7:0] ref_rd(input int a);
        return refm.exists(a) ? refm[a] : 8'h00;
    endfunction

    // Behavioural RAM: byte lanes, one-cycle read latency.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int i = 0; i < 4; i++) begin
                    if (mem_be[i]) begin
                        if (!((int'(mem_addr) + i < 32) ||
                              (int'(mem_addr) + i >= 32'h4000 && int'(mem_addr) + i < 32'h8000)))
                            stray++;
                        ram[int'(mem_addr) + i] = mem_wdata[8*i +: 8];
                    end
                end
            end else begin
                mem_rdata <= {ram_rd(int'(mem_addr) + 3), ram_rd(int'(mem_addr) + 2),
                              ram_rd(int'(mem_addr) + 1), ram_rd(int'(mem_addr))};
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every cycle: address and count against the reference model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(32'(cur_addr) == m_addr, "R2/R3 address track", 32'(cur_addr), m_addr);
            chk(32'(cur_cnt) == m_cnt, "R4 count track", 32'(cur_cnt), m_cnt);
        end
    end

    task automatic set_ptr(input int a, input int c);
        addr_load = 1'b1; addr_val = a[15:0];
        cnt_load  = 1'b1; cnt_val  = c[15:0];
        @(posedge clk); #1;
        addr_load = 1'b0; cnt_load = 1'b0;
        m_addr = a; m_cnt = c;
        @(negedge clk);
    endtask

    // One host access; the model predicts done, data and the new pointers.
    task automatic xfer(input bit we, input logic [4:0] ofs, input bit dw, input logic [31:0] wd,
                        input string tag, output logic [31:0] rd,
                        input bit ld = 1'b0, input int ldv = 0);
        int sz, a, na;
        bit ok, upd, edn, eprom;
        logic [31:0] erd;
        bit [7:0] src;
        sz = dw ? 4 : (cfg_wide ? 2 : 1);
        a  = (sz == 1) ? m_addr : (m_addr & ~1);
        ok = (a + sz <= 32) || (a >= 32'h4000 && a + sz <= 32'h8000);
        edn = 0; eprom = 0; erd = 32'hFFFF_FFFF; upd = 0;
        if (ofs == 5'h10) begin
            upd = !we || (m_cnt != 0);
            if (!we) begin
                if (ok) begin
                    erd = 0;
                    for (int i = 0; i < sz; i++) erd[8*i +: 8] = ref_rd(a + i);
                end else begin
                    erd = (sz == 4) ? 32'hFFFF_FFFF : (sz == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
                end
            end
        end else if (ofs == 5'h1F && !we) begin
            erd = 0; eprom = 1;
        end
        host_req = 1'b1; host_we = we; host_ofs = ofs; host_dword = dw; host_wdata = wd;
        addr_load = ld; addr_val = ldv[15:0];
        @(posedge clk); #1;
        host_req = 1'b0; addr_load = 1'b0;
        if (upd) begin
            if (we && ok)
                for (int i = 0; i < sz; i++) refm[a + i] = wd[8*i +: 8];
            na = (m_addr + sz) & 32'hFFFF;
            if (na == int'(ring_stop_pg) * 256) na = int'(ring_start_pg) * 256;
            m_addr = na;
            if (m_cnt <= sz) begin m_cnt = 0; edn = 1; end
            else m_cnt = m_cnt - sz;
        end
        if (ld) m_addr = ldv;
        if (eprom) begin
            for (int j = 0; j < 16; j++) begin
                src = (j < 6) ? mac_addr[8*j +: 8] : (j >= 14) ? 8'h57 : 8'h00;
                refm[2*j] = src; refm[2*j + 1] = src;
            end
        end
        @(negedge clk);
        chk(dma_done == edn, {tag, " (R4 done)"}, 32'(dma_done), 32'(edn));
        chk(prom_event == eprom, {tag, " (R10 event)"}, 32'(prom_event), 32'(eprom));
        rd = 0;
        if (!we) begin
            chk(host_rvalid == 1'b1, {tag, " (R9 rvalid)"}, 32'(host_rvalid), 1);
            rd = host_rdata;
            chk(rd == erd, {tag, " data"}, rd, erd);
            @(negedge clk);
            while (!host_ready) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; cfg_wide = 1'b0; ring_start_pg = 8'h40; ring_stop_pg = 8'h80;
        addr_load = 1'b0; addr_val = '0; cnt_load = 1'b0; cnt_val = '0;
        mac_addr = 48'h5544_3322_1102;
        host_req = 1'b0; host_we = 1'b0; host_dword = 1'b0; host_ofs = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready == 1'b1, "R1 ready after reset", 32'(host_ready), 1);
        chk(host_rvalid == 1'b0, "R1 rvalid after reset", 32'(host_rvalid), 0);
        chk(dma_done == 1'b0 && prom_event == 1'b0, "R1 pulses idle", 32'({dma_done, prom_event}), 0);
        chk(cur_addr == 16'h0 && cur_cnt == 16'h0, "R1 pointers zero", 32'({cur_addr, cur_cnt}), 0);

        // Byte writes, completion on the last one.
        set_ptr(32'h4000, 5);
        for (int i = 0; i < 5; i++) xfer(1, 5'h10, 0, 32'h11 + i, "R2 byte write", rd);
        chk(cur_addr == 16'h4005, "R2 byte advance", 32'(cur_addr), 32'h4005);

        // Write at zero count is dropped.
        xfer(1, 5'h10, 0, 32'hEE, "R5 write at zero count", rd);
        chk(cur_addr == 16'h4005, "R5 address held", 32'(cur_addr), 32'h4005);

        // Byte reads back.
        set_ptr(32'h4000, 5);
        for (int i = 0; i < 5; i++) begin
            xfer(0, 5'h10, 0, 0, "R9 byte read", rd);
            chk(rd == 32'h11 + i, "R2 byte read value", rd, 32'h11 + i);
        end

        // Read at zero count still runs; also shows the R5 write never landed.
        xfer(0, 5'h10, 0, 0, "R6 read at zero count", rd);
        chk(rd == 32'h0, "R5 dropped write absent", rd, 0);
        chk(cur_addr == 16'h4006, "R6 address advanced", 32'(cur_addr), 32'h4006);

        // 16-bit mode with an odd address, then a word read.
        cfg_wide = 1'b1;
        set_ptr(32'h4011, 3);
        xfer(1, 5'h10, 0, 32'hBEEF, "R8 half write odd", rd);
        xfer(1, 5'h10, 0, 32'h1234, "R8 half write", rd);
        set_ptr(32'h4010, 4);
        xfer(0, 5'h10, 1, 0, "R8 word read", rd);
        chk(rd == 32'h1234_BEEF, "R8 little-endian word", rd, 32'h1234_BEEF);
        chk(cur_addr == 16'h4014, "R2 word advance", 32'(cur_addr), 32'h4014);

        // Ring wrap from each size.
        set_ptr(32'h7FFE, 10);
        xfer(1, 5'h10, 0, 32'hA5A5, "R3 half wrap", rd);
        chk(cur_addr == 16'h4000, "R3 half wrap target", 32'(cur_addr), 32'h4000);
        set_ptr(32'h7FFC, 10);
        xfer(1, 5'h10, 1, 32'hCAFE_F00D, "R3 word wrap", rd);
        chk(cur_addr == 16'h4000, "R3 word wrap target", 32'(cur_addr), 32'h4000);
        cfg_wide = 1'b0;
        set_ptr(32'h7FFF, 10);
        xfer(1, 5'h10, 0, 32'h5A, "R3 byte wrap", rd);
        chk(cur_addr == 16'h4000, "R3 byte wrap target", 32'(cur_addr), 32'h4000);

        // Outside the ranges.
        set_ptr(32'h0100, 8);
        xfer(0, 5'h10, 0, 0, "R7 byte read outside", rd);
        chk(rd == 32'h0000_00FF, "R7 byte ones", rd, 32'hFF);
        cfg_wide = 1'b1;
        xfer(0, 5'h10, 0, 0, "R7 half read outside", rd);
        chk(rd == 32'h0000_FFFF, "R7 half ones", rd, 32'hFFFF);
        xfer(0, 5'h10, 1, 0, "R7 word read outside", rd);
        chk(rd == 32'hFFFF_FFFF, "R7 word ones", rd, 32'hFFFF_FFFF);
        cfg_wide = 1'b0;
        set_ptr(32'h2000, 2);
        xfer(1, 5'h10, 0, 32'h77, "R7 write outside", rd);
        chk(cur_addr == 16'h2001, "R7 update despite drop", 32'(cur_addr), 32'h2001);

        // Word straddling the end of a range.
        set_ptr(32'h7FFE, 8);
        xfer(0, 5'h10, 1, 0, "R8 word past window", rd);
        chk(rd == 32'hFFFF_FFFF, "R8 partial word ones", rd, 32'hFFFF_FFFF);
        set_ptr(32'h001E, 8);
        xfer(0, 5'h10, 1, 0, "R8 word past PROM", rd);
        chk(rd == 32'hFFFF_FFFF, "R8 partial PROM ones", rd, 32'hFFFF_FFFF);

        // PROM rebuild.
        xfer(0, 5'h1F, 0, 0, "R10 reset port read", rd);
        chk(rd == 32'h0, "R10 returns zero", rd, 0);
        set_ptr(32'h0000, 32);
        for (int k = 0; k < 8; k++) begin
            xfer(0, 5'h10, 1, 0, "R10 PROM word", rd);
            case (k)
                0: chk(rd == 32'h1111_0202, "R10 word 0", rd, 32'h1111_0202);
                1: chk(rd == 32'h3333_2222, "R10 word 1", rd, 32'h3333_2222);
                2: chk(rd == 32'h5555_4444, "R10 word 2", rd, 32'h5555_4444);
                7: chk(rd == 32'h5757_5757, "R10 word 7", rd, 32'h5757_5757);
                default: chk(rd == 32'h0, "R10 zero word", rd, 0);
            endcase
        end

        // Unclaimed offsets.
        xfer(0, 5'h05, 0, 0, "R11 undecoded read", rd);
        chk(rd == 32'hFFFF_FFFF, "R11 all ones", rd, 32'hFFFF_FFFF);
        set_ptr(32'h4100, 4);
        xfer(1, 5'h05, 0, 32'h99, "R11 undecoded write", rd);
        chk(cur_addr == 16'h4100 && cur_cnt == 16'd4, "R11 no effect", 32'({cur_addr, cur_cnt}), 32'h4100_0004);

        // Load beats a port update in the same cycle.
        set_ptr(32'h4200, 4);
        xfer(1, 5'h10, 0, 32'h3C, "R12 write with load", rd, 1'b1, 32'h4300);
        chk(cur_addr == 16'h4300, "R12 load wins", 32'(cur_addr), 32'h4300);
        chk(cur_cnt == 16'd3, "R12 count still updated", 32'(cur_cnt), 3);
        set_ptr(32'h4200, 1);
        xfer(0, 5'h10, 0, 0, "R12 readback", rd);
        chk(rd == 32'h3C, "R12 data at old address", rd, 32'h3C);

        chk(stray == 0, "R7 no stray memory write", stray, 0);
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule